// File: doc/BRIEF.md
# Separable Bicubic Resize Filter

This block computes bicubic-interpolated 8-bit pixels for image scaling. It has one kernel of eight lanes. Each lane is a four-tap multiply-accumulate, and the same kernel is used for both axes of the separable filter.

In the vertical pass, the kernel reads four input rows of eight pixels. It filters each column and returns eight signed 16-bit intermediate values. Those values are also written into one row of an internal 8x8 intermediate tile.

In the horizontal pass, the kernel reads the tile transposed. Lane r takes four neighbouring columns of tile row r, so the horizontal filter becomes the same column operation as the vertical one. The horizontal pass returns eight saturated 8-bit pixels.

A 4-bit phase picks the cubic weights for the fractional sample position. Each pass has its own accumulator preset (rounding value) and right shift, held in configuration registers. Address generation and memory access are left to the surrounding logic.

Top module: `resizeBicubic`

## Requirements
- R1: While `rstN` is low, `outValid`, `outPix`, `interOut` and every tile entry are cleared. The configuration returns to a vertical preset of 2 with shift 2, and a horizontal preset of 2048 with shift 12.
- R2: `outValid` is high in the cycle after a cycle with `inValid` high, and low in the cycle after a cycle with `inValid` low.
- R3: For phase p and t = p/16, the four weights w0..w3 apply to neighbours at offsets -1, 0, +1, +2 from the base sample. They use the cubic kernel with a = -0.5 and 7 fractional bits.
  - w0 = round(128·(-0.5t³+t²-0.5t))
  - w2 = round(128·(-1.5t³+2t²+0.5t))
  - w3 = round(128·(0.5t³-0.5t²))
  - w1 = 128-w0-w2-w3
  - round(x) is floor(x+0.5).
- R4: A vertical pass (`passH`=0) gives lane c = sat16((preset + Σk wk·Pk,c) >>> shift), using the vertical preset and shift. Pk,c is the unsigned byte at `pixIn[(k*8+c)*8 +: 8]`, and row k=0 is the topmost neighbour. The result goes to `interOut[c*16 +: 16]` and is stored in tile row `rowSel`, column c.
- R5: A horizontal pass (`passH`=1) with base b gives lane r = clamp((preset + Σt wt·M[r][b+t]) >>> shift) on `outPix[r*8 +: 8]`, using the horizontal preset and shift. M[r][j] is the tile value stored at row r, column j.
- R6: A `colBase` above 4 is treated as 4.
- R7: Intermediate results saturate to [-32768, 32767], and output pixels saturate to [0, 255].
- R8: `cfgWe` loads `cfgRound` and `cfgShift` into the vertical set (`cfgPass`=0) or the horizontal set (`cfgPass`=1). A pass in the same cycle still uses the old values, and the new values apply from the next cycle.
- R9: `outPix` changes only after a horizontal pass. `interOut` and the tile change only after a vertical pass. Configuration writes change neither.
- R10: A horizontal pass in the cycle right after a vertical pass sees the tile row that the vertical pass just wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Start a pass this cycle |
| passH | input | 1 | 0 = vertical pass on pixIn, 1 = horizontal pass on the tile |
| rowSel | input | 3 | Tile row written by a vertical pass |
| colBase | input | 3 | First tile column read by a horizontal pass |
| phase | input | 4 | Fractional position, selects the weights |
| pixIn | input | 256 | Four rows of eight unsigned pixels |
| cfgWe | input | 1 | Configuration write strobe |
| cfgPass | input | 1 | Configuration set selected: 0 vertical, 1 horizontal |
| cfgRound | input | 28 | Signed accumulator preset to load |
| cfgShift | input | 5 | Right shift to load |
| outValid | output | 1 | Result registers updated by a pass |
| outPix | output | 64 | Eight pixels from the last horizontal pass |
| interOut | output | 128 | Eight signed intermediates from the last vertical pass |

## Verification
The assertions check two things on every cycle. The first is the one-cycle timing of `outValid` against `inValid`. The second is that each output bus stays still across cycles in which no pass of its own kind ran. The arithmetic can only be shown by the bench's scenarios, which compare every lane with a model computed from the requirements:
- the weight set for each phase;
- both saturation bounds;
- the transposed reads with base clamping;
- the timing of configuration writes;
- the tile forwarding between back-to-back passes.

// File: rtl/resizePkg.sv
package resizePkg;
  localparam int LANES    = 8;
  localparam int TAPS     = 4;
  localparam int PIX_W    = 8;
  localparam int MID_W    = 16;
  localparam int COEF_W   = 9;
  localparam int FRAC_W   = 7;
  localparam int PHASE_W  = 4;
  localparam int SHIFT_W  = 5;
  localparam int ROW_W    = $clog2(LANES);
  localparam int ACC_W    = MID_W + COEF_W + $clog2(TAPS) + 1;
  localparam int BASE_MAX = LANES - TAPS;

  typedef logic [TAPS-1:0][COEF_W-1:0] weightVec_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic               fire;
    logic               horiz;
    logic [ROW_W-1:0]   slot;
    logic [ROW_W-1:0]   base;
    logic [PHASE_W-1:0] phase;
    logic [ACC_W-1:0]   roundVal;
    logic [SHIFT_W-1:0] shiftVal;
  } ctrlStrb_t;

  // Cubic (a = -0.5) weights scaled by 2^FRAC_W, centre tap absorbs rounding
  function automatic weightVec_t cubicWeights(input logic [PHASE_W-1:0] ph);
    int p, p2, p3, full, shr, scale, bias;
    int w0, w1, w2, w3;
    p     = int'(ph);
    p2    = p * p;
    p3    = p2 * p;
    full  = 1 << PHASE_W;
    shr   = 1 + 3 * PHASE_W;
    scale = 1 << FRAC_W;
    bias  = 1 << (shr - 1);
    w0 = ((-p3 + 2 * full * p2 - full * full * p) * scale + bias) >>> shr;
    w2 = ((-3 * p3 + 4 * full * p2 + full * full * p) * scale + bias) >>> shr;
    w3 = ((p3 - full * p2) * scale + bias) >>> shr;
    w1 = scale - w0 - w2 - w3;
    cubicWeights[0] = COEF_W'(w0);
    cubicWeights[1] = COEF_W'(w1);
    cubicWeights[2] = COEF_W'(w2);
    cubicWeights[3] = COEF_W'(w3);
  endfunction
endpackage

// File: rtl/resizeMacLane.sv
module resizeMacLane #(
  parameter int TAPS    = 4,
  parameter int MID_W   = 16,
  parameter int COEF_W  = 9,
  parameter int PIX_W   = 8,
  parameter int ACC_W   = 28,
  parameter int SHIFT_W = 5
) (
  input  logic [TAPS-1:0][MID_W-1:0]  opnd,
  input  logic [TAPS-1:0][COEF_W-1:0] wgt,
  input  logic [ACC_W-1:0]            roundVal,
  input  logic [SHIFT_W-1:0]          shiftVal,
  output logic [MID_W-1:0]            midSat,
  output logic [PIX_W-1:0]            pixSat
);
  localparam int PROD_W = MID_W + COEF_W;
  localparam logic signed [ACC_W-1:0] MID_HI = ACC_W'((1 << (MID_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MID_LO = ~MID_HI;
  localparam logic signed [ACC_W-1:0] PIX_HI = ACC_W'((1 << PIX_W) - 1);
  localparam logic signed [ACC_W-1:0] ZERO   = '0;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  shifted;

  always_comb begin
    acc  = $signed(roundVal);
    prod = '0;
    for (int t = 0; t < TAPS; t++) begin
      prod = $signed(opnd[t]) * $signed(wgt[t]);
      acc  = acc + ACC_W'(prod);
    end
    shifted = acc >>> shiftVal;
  end

  always_comb begin
    if (shifted > MID_HI)      midSat = MID_HI[MID_W-1:0];
    else if (shifted < MID_LO) midSat = MID_LO[MID_W-1:0];
    else                       midSat = shifted[MID_W-1:0];
  end

  always_comb begin
    if (shifted > PIX_HI)      pixSat = PIX_HI[PIX_W-1:0];
    else if (shifted < ZERO)   pixSat = '0;
    else                       pixSat = shifted[PIX_W-1:0];
  end
endmodule

// File: rtl/resizeCtrl.sv
module resizeCtrl
  import resizePkg::*;
#(
  parameter int V_ROUND_INIT = 2,
  parameter int V_SHIFT_INIT = 2,
  parameter int H_ROUND_INIT = 2048,
  parameter int H_SHIFT_INIT = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               passH,
  input  logic [ROW_W-1:0]   rowSel,
  input  logic [ROW_W-1:0]   colBase,
  input  logic [PHASE_W-1:0] phase,
  input  logic               cfgWe,
  input  logic               cfgPass,
  input  logic [ACC_W-1:0]   cfgRound,
  input  logic [SHIFT_W-1:0] cfgShift,
  output ctrlStrb_t          strb
);
  logic [ACC_W-1:0]   vRound, hRound;
  logic [SHIFT_W-1:0] vShift, hShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vRound <= ACC_W'(V_ROUND_INIT);
      vShift <= SHIFT_W'(V_SHIFT_INIT);
      hRound <= ACC_W'(H_ROUND_INIT);
      hShift <= SHIFT_W'(H_SHIFT_INIT);
    end else if (cfgWe) begin
      if (cfgPass) begin
        hRound <= cfgRound;
        hShift <= cfgShift;
      end else begin
        vRound <= cfgRound;
        vShift <= cfgShift;
      end
    end
  end

  always_comb begin
    strb.fire     = inValid;
    strb.horiz    = passH;
    strb.slot     = rowSel;
    strb.base     = (colBase > ROW_W'(BASE_MAX)) ? ROW_W'(BASE_MAX) : colBase;
    strb.phase    = phase;
    strb.roundVal = passH ? hRound : vRound;
    strb.shiftVal = passH ? hShift : vShift;
  end
endmodule

// File: rtl/resizeDatapath.sv
module resizeDatapath
  import resizePkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrb_t                     strb,
  input  logic [LANES*TAPS*PIX_W-1:0]   pixIn,
  output logic                          outValid,
  output logic [LANES*PIX_W-1:0]        outPix,
  output logic [LANES*MID_W-1:0]        interOut
);
  weightVec_t                       wVec;
  logic [MID_W-1:0]                 midBuf [LANES][LANES];
  logic [LANES-1:0][MID_W-1:0]      laneMid;
  logic [LANES-1:0][PIX_W-1:0]      lanePix;

  assign wVec = cubicWeights(strb.phase);

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [TAPS-1:0][MID_W-1:0] opnd;

    // vertical: column of pixel rows; horizontal: tile row read transposed
    always_comb begin
      for (int t = 0; t < TAPS; t++) begin
        if (strb.horiz)
          opnd[t] = midBuf[lane][strb.base + ROW_W'(t)];
        else
          opnd[t] = MID_W'(pixIn[(t*LANES + lane)*PIX_W +: PIX_W]);
      end
    end

    resizeMacLane #(
      .TAPS(TAPS), .MID_W(MID_W), .COEF_W(COEF_W),
      .PIX_W(PIX_W), .ACC_W(ACC_W), .SHIFT_W(SHIFT_W)
    ) u_mac (
      .opnd     (opnd),
      .wgt      (wVec),
      .roundVal (strb.roundVal),
      .shiftVal (strb.shiftVal),
      .midSat   (laneMid[lane]),
      .pixSat   (lanePix[lane])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPix   <= '0;
      interOut <= '0;
      for (int r = 0; r < LANES; r++)
        for (int c = 0; c < LANES; c++)
          midBuf[r][c] <= '0;
    end else begin
      outValid <= strb.fire;
      if (strb.fire && strb.horiz)
        outPix <= lanePix;
      if (strb.fire && !strb.horiz) begin
        interOut <= laneMid;
        for (int c = 0; c < LANES; c++)
          midBuf[strb.slot][c] <= laneMid[c];
      end
    end
  end
endmodule

// File: rtl/resizeBicubic.sv
module resizeBicubic
  import resizePkg::*;
#(
  parameter int V_ROUND_INIT = 2,
  parameter int V_SHIFT_INIT = 2,
  parameter int H_ROUND_INIT = 2048,
  parameter int H_SHIFT_INIT = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic                        passH,
  input  logic [ROW_W-1:0]            rowSel,
  input  logic [ROW_W-1:0]            colBase,
  input  logic [PHASE_W-1:0]          phase,
  input  logic [LANES*TAPS*PIX_W-1:0] pixIn,
  input  logic                        cfgWe,
  input  logic                        cfgPass,
  input  logic [ACC_W-1:0]            cfgRound,
  input  logic [SHIFT_W-1:0]          cfgShift,
  output logic                        outValid,
  output logic [LANES*PIX_W-1:0]      outPix,
  output logic [LANES*MID_W-1:0]      interOut
);
  ctrlStrb_t strb;

  resizeCtrl #(
    .V_ROUND_INIT(V_ROUND_INIT), .V_SHIFT_INIT(V_SHIFT_INIT),
    .H_ROUND_INIT(H_ROUND_INIT), .H_SHIFT_INIT(H_SHIFT_INIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .passH(passH),
    .rowSel(rowSel), .colBase(colBase), .phase(phase),
    .cfgWe(cfgWe), .cfgPass(cfgPass), .cfgRound(cfgRound),
    .cfgShift(cfgShift), .strb(strb)
  );

  resizeDatapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pixIn(pixIn),
    .outValid(outValid), .outPix(outPix), .interOut(interOut)
  );
endmodule

// File: rtl/resizeBicubicChk.sv
module resizeBicubicChk
  import resizePkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic                   passH,
  input logic                   outValid,
  input logic [LANES*PIX_W-1:0] outPix,
  input logic [LANES*MID_W-1:0] interOut
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R9
  pix_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && passH) |=> $stable(outPix));

  // R9
  mid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && !passH) |=> $stable(interOut));
endmodule

bind resizeBicubic resizeBicubicChk chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .passH(passH),
  .outValid(outValid), .outPix(outPix), .interOut(interOut)
);

// File: tb/resizeBicubic_test.sv
module resizeBicubic_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0, passH = 1'b0, cfgWe = 1'b0, cfgPass = 1'b0;
  logic [2:0]   rowSel = '0, colBase = '0;
  logic [3:0]   phase = '0;
  logic [255:0] pixIn = '0;
  logic [27:0]  cfgRound = '0;
  logic [4:0]   cfgShift = '0;
  logic         outValid;
  logic [63:0]  outPix;
  logic [127:0] interOut;

  int nChecks = 0, nErr = 0;
  int mBuf [8][8];
  int mvR = 2, mvS = 2, mhR = 2048, mhS = 12;

  always #5 clk = ~clk;

  resizeBicubic uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .passH(passH),
    .rowSel(rowSel), .colBase(colBase), .phase(phase), .pixIn(pixIn),
    .cfgWe(cfgWe), .cfgPass(cfgPass), .cfgRound(cfgRound),
    .cfgShift(cfgShift), .outValid(outValid), .outPix(outPix),
    .interOut(interOut)
  );

  // {phase, row0, row1, row2, row3, expected intermediate} under default config
  localparam logic [51:0] VEC [8] = '{
    {4'd0,  8'd10,  8'd20,  8'd30,  8'd40,  16'd640},
    {4'd8,  8'd10,  8'd20,  8'd30,  8'd40,  16'd800},
    {4'd8,  8'd255, 8'd255, 8'd255, 8'd255, 16'd8160},
    {4'd8,  8'd255, 8'd0,   8'd0,   8'd255, 16'hFC04},
    {4'd8,  8'd0,   8'd255, 8'd255, 8'd0,   16'd9180},
    {4'd4,  8'd0,   8'd100, 8'd0,   8'd0,   16'd2775},
    {4'd12, 8'd0,   8'd0,   8'd200, 8'd0,   16'd5550},
    {4'd15, 8'd0,   8'd0,   8'd0,   8'd100, 16'hFF9C}
  };

  function automatic int wgt(int ph, int k);
    real t;
    int a, b, c;
    t = ph / 16.0;
    a = int'($floor(128.0 * (-0.5*t*t*t + t*t - 0.5*t) + 0.5));
    b = int'($floor(128.0 * (-1.5*t*t*t + 2.0*t*t + 0.5*t) + 0.5));
    c = int'($floor(128.0 * (0.5*t*t*t - 0.5*t*t) + 0.5));
    case (k)
      0: return a;
      1: return 128 - a - b - c;
      2: return b;
      default: return c;
    endcase
  endfunction

  function automatic int getMid(int c);
    logic signed [15:0] v;
    v = interOut[c*16 +: 16];
    return int'(v);
  endfunction

  function automatic int getPix(int r);
    return int'(outPix[r*8 +: 8]);
  endfunction

  function automatic int getIn(int k, int c);
    return int'(pixIn[(k*8+c)*8 +: 8]);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic putPix(int k, int c, int v);
    pixIn[(k*8+c)*8 +: 8] = v[7:0];
  endtask

  task automatic runOp(bit h, int slot, int base, int ph);
    @(negedge clk);
    passH = h; rowSel = slot[2:0]; colBase = base[2:0]; phase = ph[3:0];
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // expected vertical result per lane, model tile updated
  task automatic expectV(int slot, int ph, string req);
    for (int c = 0; c < 8; c++) begin
      int acc;
      acc = mvR;
      for (int k = 0; k < 4; k++) acc += wgt(ph, k) * getIn(k, c);
      acc = acc >>> mvS;
      if (acc > 32767) acc = 32767;
      if (acc < -32768) acc = -32768;
      mBuf[slot][c] = acc;
      chk(req, $sformatf("vertical lane %0d", c), getMid(c), acc);
    end
  endtask

  task automatic expectH(int base, int ph, string req);
    int eb;
    eb = (base > 4) ? 4 : base;
    for (int r = 0; r < 8; r++) begin
      int acc;
      acc = mhR;
      for (int t = 0; t < 4; t++) acc += wgt(ph, t) * mBuf[r][eb+t];
      acc = acc >>> mhS;
      if (acc > 255) acc = 255;
      if (acc < 0) acc = 0;
      chk(req, $sformatf("horizontal lane %0d base %0d", r, base), getPix(r), acc);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    logic [127:0] savedMid;
    logic [63:0]  savedPix;
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) mBuf[r][c] = 0;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", "outValid in reset", int'(outValid), 0);
    chk("R1", "outPix in reset", int'(outPix != 0), 0);
    chk("R1", "interOut in reset", int'(interOut != 0), 0);
    rstN = 1'b1;
    // R1 cleared tile with default horizontal config gives zero pixels
    runOp(1'b1, 0, 2, 8);
    expectH(2, 8, "R1");
    chk("R2", "outValid after pass", int'(outValid), 1);
    @(negedge clk);
    chk("R2", "outValid idle", int'(outValid), 0);

    // R3 R4 table of vertical vectors (R1 default vertical config)
    foreach (VEC[i]) begin
      logic signed [15:0] ev;
      ev = VEC[i][15:0];
      for (int c = 0; c < 8; c++) begin
        putPix(0, c, int'(VEC[i][47:40]));
        putPix(1, c, int'(VEC[i][39:32]));
        putPix(2, c, int'(VEC[i][31:24]));
        putPix(3, c, int'(VEC[i][23:16]));
      end
      runOp(1'b0, 0, 0, int'(VEC[i][51:48]));
      for (int c = 0; c < 8; c++) begin
        chk("R3", $sformatf("vector %0d lane %0d", i, c), getMid(c), int'(ev));
        mBuf[0][c] = int'(ev);
      end
    end

    // R4 R9 fill tile with lane-varying data
    for (int s = 0; s < 8; s++) begin
      savedPix = outPix;
      for (int k = 0; k < 4; k++)
        for (int c = 0; c < 8; c++) putPix(k, c, (s*29 + c*17 + k*53 + c*c*7) % 256);
      runOp(1'b0, s, 0, s*2);
      expectV(s, s*2, "R4");
      chk("R9", "outPix held over vertical", int'(outPix == savedPix), 1);
    end

    // R5 R9 transposed horizontal passes
    for (int b = 0; b < 5; b++) begin
      for (int q = 0; q < 4; q++) begin
        int ph;
        ph = (q == 0) ? 0 : (q == 1) ? 5 : (q == 2) ? 8 : 13;
        savedMid = interOut;
        runOp(1'b1, 0, b, ph);
        expectH(b, ph, "R5");
        chk("R9", "interOut held over horizontal", int'(interOut == savedMid), 1);
      end
    end

    // R6 base above the limit acts as the limit
    runOp(1'b1, 0, 7, 9);
    expectH(7, 9, "R6");
    runOp(1'b1, 0, 6, 3);
    expectH(6, 3, "R6");

    // R10 vertical then horizontal back to back
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 8; c++) putPix(k, c, (k == 1) ? 200 - c*20 : 0);
    @(negedge clk);
    passH = 1'b0; rowSel = 3'd3; phase = 4'd0; inValid = 1'b1;
    @(negedge clk);
    passH = 1'b1; colBase = 3'd2; phase = 4'd0; inValid = 1'b1;
    expectV(3, 0, "R10");
    @(negedge clk);
    inValid = 1'b0;
    expectH(2, 0, "R10");

    // R8 config write coincident with a pass: old values used
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 8; c++) putPix(k, c, (k == 1) ? 100 : 0);
    @(negedge clk);
    cfgWe = 1'b1; cfgPass = 1'b0; cfgRound = '0; cfgShift = '0;
    passH = 1'b0; rowSel = 3'd4; phase = 4'd0; inValid = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
    chk("R8", "same-cycle write uses old config", getMid(0), 3200);
    expectV(4, 0, "R8");
    mvR = 0; mvS = 0;
    @(negedge clk);
    inValid = 1'b0;
    chk("R8", "next pass uses new config", getMid(0), 12800);
    expectV(4, 0, "R8");

    // R7 intermediate saturation
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 8; c++) putPix(k, c, (k == 1 || k == 2) ? 255 : 0);
    runOp(1'b0, 5, 0, 8);
    chk("R7", "intermediate upper bound", getMid(2), 32767);
    expectV(5, 8, "R7");
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 8; c++) putPix(k, c, (k == 0 || k == 3) ? 255 : 0);
    runOp(1'b0, 6, 0, 8);
    expectV(6, 8, "R7");
    // R7 pixel saturation high (row 5) and low (row 6)
    runOp(1'b1, 0, 1, 0);
    chk("R7", "pixel upper bound", getPix(5), 255);
    chk("R7", "pixel lower bound", getPix(6), 0);
    expectH(1, 0, "R7");

    // R9 R8 idle config write leaves outputs alone, then takes effect
    savedPix = outPix;
    savedMid = interOut;
    @(negedge clk);
    cfgWe = 1'b1; cfgPass = 1'b1; cfgRound = 28'd64; cfgShift = 5'd7;
    @(negedge clk);
    cfgWe = 1'b0;
    @(negedge clk);
    chk("R9", "outPix after config write", int'(outPix == savedPix), 1);
    chk("R9", "interOut after config write", int'(interOut == savedMid), 1);
    chk("R2", "outValid after config write", int'(outValid), 0);
    mhR = 64; mhS = 7;
    runOp(1'b1, 0, 3, 11);
    expectH(3, 11, "R8");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule